// File: doc/BRIEF.md
# Multicycle Eight-Bit Load/Store Processor Core

This block is a compact multicycle processor. It has four 8-bit general registers, a 6-bit program counter and one 64-word memory that holds both instructions and data. Each memory word is 16 bits wide. The core fetches a word, decodes it and executes one of five operations: register add, load, store, branch-if-equal and absolute jump. A sixth encoding halts the machine. Every instruction takes a fixed number of cycles, so a program's timeline can be worked out ahead of time.

The memory has no reset. Before the program starts, a side load port fills it, normally while reset is held. Debug outputs show the register file and the program counter at all times. A debug read port returns any memory word combinationally. A done flag rises when the halt instruction retires.

Top module: `tcpu_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `dbg_pc` equal to `START_PC`, all registers zero and `done` low. Memory contents are not changed by reset.
- R2: Each instruction takes exactly three cycles: fetch, execute, commit. Registers, memory and `dbg_pc` change only at the commit edge. The first commit comes at the third rising edge after reset is released.
- R3: Opcode 3'b000 (add) writes (reg[rs] + reg[rt2]) mod 256 into reg[rd].
- R4: Opcode 3'b001 (load) writes the low 8 bits of memory[(reg[rs] + imm) mod 64] into reg[rd]. The immediate is added without regard to sign, so the address wraps at 64.
- R5: Opcode 3'b010 (store) writes reg[rd] into the low byte of memory[(reg[rs] + imm) mod 64] and clears the upper byte of that word.
- R6: After add, load, store, or an undefined opcode (3'b101, 3'b110), the PC becomes (PC + 1) mod 64.
- R7: Opcode 3'b011 (branch) compares reg[rs] with reg[rt2]. If they differ, the PC becomes PC + 1. If they are equal, the PC becomes (PC + 1 + sign-extended imm) mod 64.
- R8: Opcode 3'b100 (jump) loads the PC with imm[5:0] as an absolute address.
- R9: Opcode 3'b111 (halt) raises `done` at its commit edge. From then on `done` stays high and the PC, the registers and the memory do not change until reset.
- R10: The word layout is op = bits 15:13, rd = bits 12:11, rs = bits 10:9, rt2 = bits 8:7, bit 6 unused, imm/target = bits 5:0.
- R11: When `ld_we` is high at a rising edge, `ld_data` is written to memory[`ld_addr`], with or without reset. `dbg_mem_q` always shows memory[`dbg_addr`] with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Side load write enable |
| ld_addr | input | 6 | Side load word address |
| ld_data | input | 16 | Side load word |
| dbg_addr | input | 6 | Debug memory read address |
| dbg_mem_q | output | 16 | Memory word at `dbg_addr` |
| dbg_rf | output | 32 | Registers packed, r0 in bits 7:0 up to r3 in bits 31:24 |
| dbg_pc | output | 6 | Program counter |
| done | output | 1 | Halt has retired |

## Verification
The hardest cases to reach from the ports are a taken branch with a negative offset, a load whose base plus offset wraps past address 63, and an add that overflows 8 bits. Each needs specific register values in place first. The registers can only be set by executing code, so the bench preloads a prologue that loads constants into the registers and then jumps into the main sequence. Later jumps reach a section that builds an overflowing sum, branches backward, and performs a wrapping load before halting. Untaken filler words sit on skipped paths; they alter a register if the core ever executes them.

// File: rtl/tcpu_pkg.sv
// Shared encodings and types for the multicycle load/store core.
// Assumes a fixed 16-bit instruction word with 2-bit register fields.
package tcpu_pkg;
    localparam int INSN_W   = 16;
    localparam int NUM_GPR  = 4;
    localparam int RIDX_W   = $clog2(NUM_GPR);
    localparam int IMM_W    = 6;
    localparam int ADDR_W   = IMM_W;
    localparam int MEM_DEPTH = 1 << ADDR_W;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_LD   = 3'b001,
        OP_ST   = 3'b010,
        OP_BEQ  = 3'b011,
        OP_JMP  = 3'b100,
        OP_HALT = 3'b111
    } opcode_e;

    typedef struct packed {
        logic [2:0]        op;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt2;
        logic              spare;
        logic [IMM_W-1:0]  imm;
    } insn_t;

    typedef struct packed {
        logic wr_reg;
        logic from_mem;
        logic wr_mem;
        logic is_beq;
        logic is_jmp;
        logic is_halt;
    } ctl_t;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_EXEC   = 2'd1,
        PH_COMMIT = 2'd2,
        PH_HALT   = 2'd3
    } phase_e;
endpackage

// File: rtl/tcpu_decode.sv
// Instruction decoder: turns the opcode field into control flags.
// Assumes undefined opcodes behave as no-operations that step the PC.
module tcpu_decode
    import tcpu_pkg::*;
(
    input  insn_t insn,
    output ctl_t  ctl
);
    // Map each opcode to its control flags.
    always_comb begin
        ctl = '0;
        case (insn.op)
            OP_ADD:  ctl.wr_reg  = 1'b1;
            OP_LD:   begin ctl.wr_reg = 1'b1; ctl.from_mem = 1'b1; end
            OP_ST:   ctl.wr_mem  = 1'b1;
            OP_BEQ:  ctl.is_beq  = 1'b1;
            OP_JMP:  ctl.is_jmp  = 1'b1;
            OP_HALT: ctl.is_halt = 1'b1;
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/tcpu_regfile.sv
// General register file: two combinational read ports, one write port.
// Assumes a synchronous active-low reset that clears every register.
module tcpu_regfile
    import tcpu_pkg::*;
#(
    parameter int DATA_W = 8
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [RIDX_W-1:0]         waddr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [RIDX_W-1:0]         raddr_a,
    input  logic [RIDX_W-1:0]         raddr_b,
    output logic [DATA_W-1:0]         rdata_a,
    output logic [DATA_W-1:0]         rdata_b,
    output logic [NUM_GPR*DATA_W-1:0] flat
);
    logic [DATA_W-1:0] regs_q [NUM_GPR];

    // One storage element per register, cleared on reset.
    for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (we && waddr == RIDX_W'(g))
                regs_q[g] <= wdata;
        end
        assign flat[g*DATA_W +: DATA_W] = regs_q[g];
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];
endmodule

// File: rtl/tcpu_mem.sv
// Unified instruction/data memory, not reset.
// The side load port wins over a core store aimed at the same cycle.
module tcpu_mem
    import tcpu_pkg::*;
(
    input  logic              clk,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [INSN_W-1:0] ld_data,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [INSN_W-1:0] core_wdata,
    output logic [INSN_W-1:0] core_rdata,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [INSN_W-1:0] dbg_rdata
);
    logic [INSN_W-1:0] words_q [MEM_DEPTH];

    // Write either the side load word or the core store word.
    always_ff @(posedge clk) begin
        if (ld_we)
            words_q[ld_addr] <= ld_data;
        else if (core_we)
            words_q[core_addr] <= core_wdata;
    end

    assign core_rdata = words_q[core_addr];
    assign dbg_rdata  = words_q[dbg_addr];
endmodule

// File: rtl/tcpu_core.sv
// Multicycle core top: fetch, execute and commit phases, one instruction
// per three cycles. Assumes the memory is preloaded through the side port
// before reset is released.
module tcpu_core
    import tcpu_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int START_PC = 0
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_we,
    input  logic [ADDR_W-1:0]         ld_addr,
    input  logic [INSN_W-1:0]         ld_data,
    input  logic [ADDR_W-1:0]         dbg_addr,
    output logic [INSN_W-1:0]         dbg_mem_q,
    output logic [NUM_GPR*DATA_W-1:0] dbg_rf,
    output logic [ADDR_W-1:0]         dbg_pc,
    output logic                      done
);
    localparam int PAD_W = INSN_W - DATA_W;

    phase_e            phase_q;
    insn_t             ir_q;
    ctl_t              ctl;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] ea_q;
    logic [DATA_W-1:0] sum_q;
    logic [DATA_W-1:0] st_data_q;
    logic              eq_q;
    logic              done_q;

    logic [DATA_W-1:0] rd_a;
    logic [DATA_W-1:0] rd_b;
    logic [RIDX_W-1:0] sel_b;
    logic [INSN_W-1:0] mem_q;
    logic [ADDR_W-1:0] mem_addr;
    logic              commit;
    logic              rf_we;
    logic [DATA_W-1:0] rf_wdata;
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] pc_next;

    tcpu_decode u_dec (
        .insn (ir_q),
        .ctl  (ctl)
    );

    // The second read port serves the store source or the second operand.
    assign sel_b = ctl.wr_mem ? ir_q.rd : ir_q.rt2;

    tcpu_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (ir_q.rd),
        .wdata   (rf_wdata),
        .raddr_a (ir_q.rs),
        .raddr_b (sel_b),
        .rdata_a (rd_a),
        .rdata_b (rd_b),
        .flat    (dbg_rf)
    );

    assign commit   = (phase_q == PH_COMMIT);
    assign mem_addr = (phase_q == PH_FETCH) ? pc_q : ea_q;

    tcpu_mem u_mem (
        .clk        (clk),
        .ld_we      (ld_we),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .core_we    (commit && ctl.wr_mem),
        .core_addr  (mem_addr),
        .core_wdata ({{PAD_W{1'b0}}, st_data_q}),
        .core_rdata (mem_q),
        .dbg_addr   (dbg_addr),
        .dbg_rdata  (dbg_mem_q)
    );

    // Register write data: the memory low byte for loads, the sum for add.
    assign rf_we    = commit && ctl.wr_reg;
    assign rf_wdata = ctl.from_mem ? mem_q[DATA_W-1:0] : sum_q;

    // Next PC: taken branch, jump target, hold on halt, or step by one.
    assign pc_inc = pc_q + ADDR_W'(1);
    always_comb begin
        if (ctl.is_halt)
            pc_next = pc_q;
        else if (ctl.is_jmp)
            pc_next = ir_q.imm;
        else if (ctl.is_beq && eq_q)
            pc_next = pc_inc + ir_q.imm;
        else
            pc_next = pc_inc;
    end

    // Phase sequencer and per-phase datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_FETCH;
            ir_q      <= '0;
            pc_q      <= ADDR_W'(START_PC);
            ea_q      <= '0;
            sum_q     <= '0;
            st_data_q <= '0;
            eq_q      <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            case (phase_q)
                PH_FETCH: begin
                    ir_q    <= mem_q;
                    phase_q <= PH_EXEC;
                end
                PH_EXEC: begin
                    ea_q      <= rd_a[ADDR_W-1:0] + ir_q.imm;
                    sum_q     <= rd_a + rd_b;
                    st_data_q <= rd_b;
                    eq_q      <= (rd_a == rd_b);
                    phase_q   <= PH_COMMIT;
                end
                PH_COMMIT: begin
                    pc_q <= pc_next;
                    if (ctl.is_halt) begin
                        done_q  <= 1'b1;
                        phase_q <= PH_HALT;
                    end else begin
                        phase_q <= PH_FETCH;
                    end
                end
                default: phase_q <= PH_HALT;
            endcase
        end
    end

    assign dbg_pc = pc_q;
    assign done   = done_q;
endmodule

// File: rtl/tcpu_core_chk.sv
// Property checker for the core, bound to every instance of the top.
// Assumes commit is high only in the commit phase.
module tcpu_core_chk
    import tcpu_pkg::*;
#(
    parameter int DATA_W = 8
)(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      commit,
    input logic [2:0]                op,
    input logic [IMM_W-1:0]          imm,
    input logic [ADDR_W-1:0]         dbg_pc,
    input logic [NUM_GPR*DATA_W-1:0] dbg_rf,
    input logic                      done
);
    logic [1:0]        cadence_q;
    logic [ADDR_W-1:0] pc_plus1;
    logic              steps;

    // Count phases independently of the core's sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cadence_q <= 2'd0;
        else if (!done)
            cadence_q <= (cadence_q == 2'd2) ? 2'd0 : cadence_q + 2'd1;
    end

    assign pc_plus1 = dbg_pc + ADDR_W'(1);
    assign steps    = (op == 3'b000) || (op == 3'b001) || (op == 3'b010);

    AST_COMMIT_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (commit == (cadence_q == 2'd2)));                              // R2
    AST_STATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(dbg_pc) && $stable(dbg_rf)));                       // R2
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && steps) |=> (dbg_pc == $past(pc_plus1)));                      // R6
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op == 3'b100) |=> (dbg_pc == $past(imm)));                    // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);                                                          // R9
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(dbg_pc) && $stable(dbg_rf)));                          // R9
endmodule

bind tcpu_core tcpu_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .op     (ir_q.op),
    .imm    (ir_q.imm),
    .dbg_pc (dbg_pc),
    .dbg_rf (dbg_rf),
    .done   (done)
);

// File: tb/tcpu_core_tb.sv
// Bench: behavioural instruction model stepped every third clock and
// compared with the core's debug ports on every falling edge.
module tcpu_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int START      = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_we;
    logic [5:0]  ld_addr;
    logic [15:0] ld_data;
    logic [5:0]  dbg_addr;
    logic [15:0] dbg_mem_q;
    logic [31:0] dbg_rf;
    logic [5:0]  dbg_pc;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;

    int img   [64];
    int m_mem [64];
    int m_rf  [4];
    int m_pc;
    int m_done;
    int m_phase;
    int trace [$];
    int last_pc;
    bit running = 0;

    tcpu_core #(.DATA_W(8), .START_PC(START)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .dbg_addr(dbg_addr), .dbg_mem_q(dbg_mem_q),
        .dbg_rf(dbg_rf), .dbg_pc(dbg_pc), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Build a word: op[15:13] rd[12:11] rs[10:9] rt2[8:7] imm[5:0] (R10).
    function automatic int enc(int op, int rd, int rs, int rt2, int imm);
        return (op << 13) | (rd << 11) | (rs << 9) | (rt2 << 7) | (imm & 63);
    endfunction

    // Execute one instruction on the model state.
    task automatic model_step();
        int w, op, rd, rs, rt2, imm, ea, soff;
        w   = m_mem[m_pc];
        op  = (w >> 13) & 7;
        rd  = (w >> 11) & 3;
        rs  = (w >> 9) & 3;
        rt2 = (w >> 7) & 3;
        imm = w & 63;
        ea  = (m_rf[rs] + imm) % 64;
        case (op)
            0: begin m_rf[rd] = (m_rf[rs] + m_rf[rt2]) % 256; m_pc = (m_pc + 1) % 64; end
            1: begin m_rf[rd] = m_mem[ea] % 256; m_pc = (m_pc + 1) % 64; end
            2: begin m_mem[ea] = m_rf[rd]; m_pc = (m_pc + 1) % 64; end
            3: begin
                soff = (imm >= 32) ? imm - 64 : imm;
                if (m_rf[rs] == m_rf[rt2]) m_pc = (m_pc + 1 + soff + 64) % 64;
                else                       m_pc = (m_pc + 1) % 64;
            end
            4: m_pc = imm;
            7: m_done = 1;
            default: m_pc = (m_pc + 1) % 64;
        endcase
    endtask

    // Reference model: reset, then one retirement per three rising edges.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_rf[i] = 0;
            m_pc = START; m_done = 0; m_phase = 0;
        end else if (m_done == 0) begin
            m_phase++;
            if (m_phase == 3) begin
                m_phase = 0;
                model_step();
            end
        end
    end

    // Per-cycle comparison away from the active edge; sweeps memory too.
    always @(negedge clk) begin
        if (running) begin
            check("R2 pc", int'(dbg_pc), m_pc);
            for (int i = 0; i < 4; i++)
                check("R2 reg", int'(dbg_rf[i*8 +: 8]), m_rf[i]);
            check("R9 done", int'(done), m_done);
            check("R11 mem", int'(dbg_mem_q), m_mem[dbg_addr]);
            if (done && dbg_addr == 6'd2) check("R5 stored word", int'(dbg_mem_q), 8);
            if (dbg_addr == 6'd0) check("R11 preload", int'(dbg_mem_q), 4);
            if (int'(dbg_pc) != last_pc) begin
                trace.push_back(int'(dbg_pc));
                last_pc = int'(dbg_pc);
            end
            dbg_addr <= dbg_addr + 6'd1;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 5000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int exp_trace [$];
        rst_n = 1'b0; ld_we = 1'b0; ld_addr = '0; ld_data = '0; dbg_addr = '0;
        for (int i = 0; i < 64; i++) img[i] = 0;
        img[0] = 4; img[1] = 0; img[2] = 2; img[3] = 7;
        img[30] = 2; img[31] = 20; img[32] = 12; img[33] = 8; img[36] = 200;
        // Prologue: registers from constants, then into the main sequence.
        img[10] = enc(1, 1, 0, 0, 31);
        img[11] = enc(1, 2, 0, 0, 32);
        img[12] = enc(1, 3, 0, 0, 33);
        img[13] = enc(1, 0, 0, 0, 30);
        img[14] = enc(4, 0, 0, 0, 20);
        img[20] = enc(0, 1, 2, 3, 0);
        img[21] = enc(1, 2, 0, 0, 1);
        img[22] = enc(2, 3, 0, 0, 0);
        img[23] = enc(3, 0, 0, 1, 2);
        img[24] = enc(4, 0, 0, 0, 15);
        img[15] = enc(3, 0, 2, 2, 3);
        for (int i = 16; i < 19; i++) img[i] = enc(0, 0, 1, 1, 0);
        img[19] = enc(4, 0, 0, 0, 40);
        img[40] = enc(1, 2, 0, 0, 34);
        img[41] = enc(0, 1, 2, 2, 0);
        img[42] = enc(4, 0, 0, 0, 50);
        img[50] = enc(3, 0, 3, 3, -7);
        img[51] = enc(0, 0, 1, 1, 0);
        img[44] = enc(1, 3, 0, 0, 63);
        img[45] = enc(7, 0, 0, 0, 0);
        for (int i = 0; i < 64; i++) m_mem[i] = img[i];

        // Preload through the side port while reset is held.
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            ld_we = 1'b1; ld_addr = 6'(i); ld_data = 16'(img[i]);
        end
        @(negedge clk);
        ld_we = 1'b0;
        @(negedge clk);
        check("R1 reset pc", int'(dbg_pc), START);
        check("R1 reset regs", int'(dbg_rf), 0);
        check("R1 reset done", int'(done), 0);
        check("R11 debug read", int'(dbg_mem_q), 4);

        last_pc = START;
        rst_n   = 1'b1;
        running = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R2 no early commit", int'(dbg_pc), START);
        @(negedge clk);
        check("R2 first commit", int'(dbg_pc), START + 1);

        repeat (130) @(negedge clk);
        running = 1'b0;

        check("R3 add wraps", int'(dbg_rf[15:8]), 144);
        check("R4 load", int'(dbg_rf[23:16]), 200);
        check("R4 wrapped address", int'(dbg_rf[31:24]), 0);
        check("R3 r0 untouched by skipped words", int'(dbg_rf[7:0]), 2);
        check("R9 done", int'(done), 1);
        check("R9 pc held at halt", int'(dbg_pc), 45);

        exp_trace = '{11, 12, 13, 14, 20, 21, 22, 23, 24, 15, 19, 40, 41, 42, 50, 44, 45};
        check("R6 trace length", trace.size(), exp_trace.size());
        if (trace.size() == exp_trace.size()) begin
            check("R7 not taken", trace[8], 24);
            check("R8 jump", trace[9], 15);
            check("R7 taken forward", trace[10], 19);
            check("R7 taken backward", trace[15], 44);
            for (int i = 0; i < exp_trace.size(); i++)
                check("R6 trace", trace[i], exp_trace[i]);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule